// File: doc/BRIEF.md
# Guarded Power-Mode Entry Controller

This block holds the power-control register of a small microcontroller and decides when the core may drop into idle or power-down. Two independent guards must both agree before either low-power request is raised. The first is an active-low hardware permit pin, which is resynchronised inside the block. The second is a two-write software handshake on the register port. The permit pin resets to its protective (high) meaning, so an undriven or unsettled pin never opens the path. A power-fail detector can pull it low at any moment, and the service routine that follows can then run the handshake.

The register has an arm bit and a request bit for each mode. The first write loads the arm bits. The write on the very next bus access completes entry for every requested mode whose arm bit is already set. A bus access of any other kind in between drops the arms. Idle ends on a wake interrupt. Power-down ends only on the external reset.

Top module: `pwrmode_guard`

## Requirements
- R1: After reset, `idle_req` and `pd_req` are low and a read of the control address returns 0x00.
- R2: While the synchronised permit is high (`pwr_en_n` = 1), a complete arm-then-request sequence raises neither output, and the request bits read back as zero.
- R3: With the permit low, a write of 0x04 (idle arm, bit 2) followed on the next access by a write of 0x01 (idle request, bit 0) raises `idle_req` one clock after the second write.
- R4: With the permit low, a write of 0x08 (power-down arm, bit 3) followed by a write of 0x02 (power-down request, bit 1) raises `pd_req`.
- R5: A request bit only takes effect when its arm bit was set by the previous access. A single write carrying both arm and request bits (0x05) enters no mode.
- R6: A read, or a write to any other address, between the arming write and the request write clears the arm bits, and the later request has no effect.
- R7: When one completed sequence asks for both modes, only `pd_req` is raised. The two outputs are never high together.
- R8: A `wake_irq` pulse clears the idle request and both arm bits. It leaves the power-down request unchanged.
- R9: Once raised, `pd_req` stays high until `rst`, which clears every register bit.
- R10: The permit passes through a two-stage synchroniser. A request write on the second clock edge after `pwr_en_n` falls is still blocked, and a sequence that finishes two edges later succeeds.
- R11: A read of the control address returns {pd_arm, idle_arm, pd_req, idle_req} in bits 3..0, with the upper bits zero. A read of any other address returns 0. A write of arm bits only (0x0C) reads back as 0x0C.

Note on R5 and R6: a control write always reloads the arm bits from its own data bits 3..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high; the only exit from power-down |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| pwr_en_n | input | 1 | Asynchronous active-low permit for power-saving entry |
| wake_irq | input | 1 | Enabled interrupt that ends idle |
| idle_req | output | 1 | Idle mode request to the core |
| pd_req | output | 1 | Power-down request to the core |

## Verification
A corrupted arm bit is the hardest fault to see, because nothing leaves the block until a request write arrives. A spuriously kept arm shows up as a mode being raised one clock after a request write that should have been rejected. A lost arm shows up as a mode that never rises. The readback of the register exposes arm state at once, before any request is made. A synchroniser with the wrong depth only shows up as a shifted boundary in R10, so the bench probes the exact edge at which the permit becomes effective. Errors in the sticky mode bits show up on the outputs on the clock after a wake pulse or an unrelated access.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    // Control register image, bits 3..0 (upper data bits read as zero)
    typedef struct packed {
        logic pd_arm;     // bit 3
        logic idle_arm;   // bit 2
        logic pd_mode;    // bit 1
        logic idle_mode;  // bit 0
    } pctl_state_t;

    localparam int unsigned PCTL_BITS = $bits(pctl_state_t);

    localparam pctl_state_t PCTL_CLEAR = '0;

    function automatic pctl_state_t pctl_from_bits(input logic [PCTL_BITS-1:0] b);
        return pctl_state_t'(b);
    endfunction

endpackage

// File: rtl/pwrctl_sync.sv
module pwrctl_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg_q <= RESET_VAL;
                else     stg_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= {STAGES{RESET_VAL}};
                else     stg_q <= {stg_q[LAST-1:0], async_i};
            end
        end
    endgenerate

    assign sync_o = stg_q[LAST];

endmodule

// File: rtl/pwrctl_seq.sv
module pwrctl_seq
    import pwrctl_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 8,
    parameter int unsigned     DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              en_ok,
    input  logic              wake,
    output pctl_state_t       state_o
);
    pctl_state_t st_q, st_d, wr_img;
    logic        ctrl_wr, want_idle, want_pd;

    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:PCTL_BITS];

    assign wr_img    = pctl_from_bits(bus_wdata[PCTL_BITS-1:0]);
    assign ctrl_wr   = bus_valid && bus_write && (bus_addr == CTRL_ADDR);
    assign want_idle = wr_img.idle_mode && st_q.idle_arm && en_ok;
    assign want_pd   = wr_img.pd_mode   && st_q.pd_arm   && en_ok;

    always_comb begin
        st_d = st_q;
        if (wake) begin
            st_d.idle_mode = 1'b0;
            st_d.idle_arm  = 1'b0;
            st_d.pd_arm    = 1'b0;
        end else if (ctrl_wr) begin
            st_d.idle_arm = wr_img.idle_arm;
            st_d.pd_arm   = wr_img.pd_arm;
            if (want_pd) begin
                st_d.pd_mode   = 1'b1;
                st_d.idle_mode = 1'b0;
            end else if (want_idle && !st_q.pd_mode) begin
                st_d.idle_mode = 1'b1;
            end
        end else if (bus_valid) begin
            st_d.idle_arm = 1'b0;
            st_d.pd_arm   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PCTL_CLEAR;
        else     st_q <= st_d;
    end

    assign state_o = st_q;

    // R2 / R10: no mode may rise unless the synchronised permit allowed it
    p_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.idle_mode) || $rose(st_q.pd_mode)) |-> $past(en_ok));

    // R5: entry only follows an arm set by the previous access
    p_need_arm_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.idle_mode) |-> $past(st_q.idle_arm));

    p_need_pd_arm_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pd_mode) |-> $past(st_q.pd_arm));

    // R7: modes are exclusive
    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(st_q.idle_mode && st_q.pd_mode));

    // R8: wake ends idle and drops arms
    p_wake_r8: assert property (@(posedge clk) disable iff (rst)
        wake |=> (!st_q.idle_mode && !st_q.idle_arm && !st_q.pd_arm));

    // R9: power-down is sticky until reset
    p_pd_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.pd_mode |=> st_q.pd_mode);

endmodule

// File: rtl/pwrmode_guard.sv
module pwrmode_guard
    import pwrctl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h87,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_en_n,
    input  logic              wake_irq,
    output logic              idle_req,
    output logic              pd_req
);
    logic        en_n_sync;
    pctl_state_t st;

    pwrctl_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pwr_en_n),
        .sync_o  (en_n_sync)
    );

    pwrctl_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_ok     (!en_n_sync),
        .wake      (wake_irq),
        .state_o   (st)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) bus_rdata[PCTL_BITS-1:0] = st;
    end

    assign idle_req = st.idle_mode;
    assign pd_req   = st.pd_mode;

    // R1: outputs low the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!idle_req && !pd_req));

endmodule

// File: tb/tb_pwrmode_guard.sv
module tb_pwrmode_guard;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CTRL = 8'h87;
    localparam logic [7:0] OTHER = 8'h42;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pwr_en_n = 1'b1;
    logic       wake_irq = 1'b0;
    logic       idle_req, pd_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrmode_guard dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_en_n(pwr_en_n), .wake_irq(wake_irq),
        .idle_req(idle_req), .pd_req(pd_req)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wake();
        wake_irq = 1'b1;
        @(posedge clk); @(negedge clk);
        wake_irq = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);   // let the synchroniser follow the pin
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(CTRL, d);
        check("R1", "ctrl read", d, 8'h00);
        check("R1", "idle_req", {7'b0, idle_req}, 8'h00);
        check("R1", "pd_req", {7'b0, pd_req}, 8'h00);
    endtask

    task automatic t_blocked();
        logic [7:0] d;
        wr(CTRL, 8'h04); wr(CTRL, 8'h01);
        check("R2", "idle_req blocked", {7'b0, idle_req}, 8'h00);
        wr(CTRL, 8'h08); wr(CTRL, 8'h02);
        check("R2", "pd_req blocked", {7'b0, pd_req}, 8'h00);
        rd(CTRL, d);
        check("R2", "mode bits read zero", d, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(CTRL, 8'h0C);
        rd(CTRL, d);
        check("R11", "arm readback", d, 8'h0C);
        rd(CTRL, d);
        check("R6", "read cleared arms", d, 8'h00);
        rd(OTHER, d);
        check("R11", "other address reads 0", d, 8'h00);
    endtask

    task automatic t_idle_and_wake();
        logic [7:0] d;
        wr(CTRL, 8'h04); wr(CTRL, 8'h01);
        check("R3", "idle_req set", {7'b0, idle_req}, 8'h01);
        check("R3", "pd_req stays low", {7'b0, pd_req}, 8'h00);
        rd(CTRL, d);
        check("R11", "idle readback", d, 8'h01);
        wake();
        check("R8", "wake clears idle", {7'b0, idle_req}, 8'h00);
        wr(CTRL, 8'h04);
        wake();
        wr(CTRL, 8'h01);
        check("R8", "wake cleared arm", {7'b0, idle_req}, 8'h00);
    endtask

    task automatic t_single_write();
        logic [7:0] d;
        wr(CTRL, 8'h05);
        check("R5", "single write no entry", {7'b0, idle_req}, 8'h00);
        rd(CTRL, d);
        check("R5", "only arm latched", d, 8'h04);
    endtask

    task automatic t_interrupted();
        logic [7:0] d;
        wr(CTRL, 8'h04); rd(OTHER, d); wr(CTRL, 8'h01);
        check("R6", "read between", {7'b0, idle_req}, 8'h00);
        wr(CTRL, 8'h08); wr(OTHER, 8'h02); wr(CTRL, 8'h02);
        check("R6", "foreign write between", {7'b0, pd_req}, 8'h00);
    endtask

    task automatic t_pd_alone();
        logic [7:0] d;
        wr(CTRL, 8'h08); wr(CTRL, 8'h02);
        check("R4", "pd_req set", {7'b0, pd_req}, 8'h01);
        rd(CTRL, d);
        check("R4", "pd readback", d, 8'h02);
        wake();
        check("R9", "wake leaves pd", {7'b0, pd_req}, 8'h01);
        wr(OTHER, 8'h00);
        check("R9", "pd sticky", {7'b0, pd_req}, 8'h01);
        do_reset();
        check("R9", "reset clears pd", {7'b0, pd_req}, 8'h00);
    endtask

    task automatic t_both();
        wr(CTRL, 8'h0C); wr(CTRL, 8'h03);
        check("R7", "pd wins", {7'b0, pd_req}, 8'h01);
        check("R7", "idle not raised", {7'b0, idle_req}, 8'h00);
        do_reset();
    endtask

    task automatic t_sync_edge();
        pwr_en_n = 1'b1;
        do_reset();
        pwr_en_n = 1'b0;
        wr(CTRL, 8'h04); wr(CTRL, 8'h01);
        check("R10", "second edge still blocked", {7'b0, idle_req}, 8'h00);
        wr(CTRL, 8'h04); wr(CTRL, 8'h01);
        check("R10", "entry after sync", {7'b0, idle_req}, 8'h01);
        do_reset();
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog expired");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none
        @(negedge clk);
        do_reset();
        t_reset();
        t_blocked();
        pwr_en_n = 1'b0;
        repeat (3) @(negedge clk);
        t_readback();
        t_idle_and_wake();
        t_single_write();
        t_interrupted();
        t_pd_alone();
        t_both();
        t_sync_edge();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule